// File: doc/BRIEF.md
# Branch trace record logger

This block sits beside a processor pipeline and copies branch trace records into a buffer held in memory. Each record carries a source address, a destination address and a 2-bit privilege tag. The block takes one record per cycle on a valid/ready handshake. It decides whether to keep the record, and if so issues a single write on its memory write port one cycle later, at the current write index.

Software reaches four registers through a simple register port: a control word, and the buffer's base, index and limit pointers. The pointers count entries, and the limit is exclusive. Control bits turn storing on and off, drop records by privilege level, and choose what happens when the buffer is full. In circular mode the index returns to the base and the oldest entries are overwritten. In interrupt mode the block raises an interrupt request, and it drops records until software moves the index back below the limit.

Top module: `btrace_logger`

## Requirements
- R1: After reset, all four registers read zero, `irq_o` is low and `mem_we_o` is low.
- R2: Register addresses are 0 control, 1 base, 2 index and 3 limit. Control bits 6:0 are writable. Bits 0, 1 and 2 are stored without further effect. Control bits 31:7 read zero and ignore writes. Pointers are `PTR_W` bits wide and read back zero-extended.
- R3: When control bit 3 (store) is set and a record is accepted and kept, `mem_we_o` is high in the next cycle. `mem_addr_o` then equals the index before the write, and `mem_wdata_o` is {priv[65:64], dst[63:32], src[31:0]}. The index then advances by one. `rec_ready_o` is always high.
- R4: When control bit 3 is clear, no record is written and the index does not move.
- R5: When control bit 5 is set, records with privilege tag 0 are dropped.
- R6: When control bit 6 is set, records with a nonzero privilege tag are dropped.
- R7: When bits 5 and 6 are both set, every record is dropped, and the control register still reads back with bit 3 and both filter bits set.
- R8: With control bit 4 clear (circular mode), after a kept record the index becomes the base if index+1 is at or above the limit, and index+1 otherwise.
- R9: `irq_o` equals bit 3 AND bit 4 AND (index >= limit), taken from the registered state. While it is high, records are dropped and the index holds.
- R10: Once raised, `irq_o` stays high until a register write changes the state, for example an index write below the limit.
- R11: When a record and a register write fall in the same cycle, the record uses the control and index values from before the write, and the written value wins in the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rec_valid_i | input | 1 | Record offered |
| rec_ready_o | output | 1 | Record accepted (always high) |
| rec_src_i | input | ADDR_W | Branch source address |
| rec_dst_i | input | ADDR_W | Branch destination address |
| rec_priv_i | input | 2 | Privilege tag, 0 = supervisor |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| mem_we_o | output | 1 | Buffer write strobe |
| mem_addr_o | output | PTR_W | Buffer entry index |
| mem_wdata_o | output | 2*ADDR_W+2 | Record written to the buffer |
| irq_o | output | 1 | Buffer-full interrupt request |

## Verification
Two functions can fall in the same cycle: a kept record, which advances the index or wraps it, and a software write to the index or control register. The bench provokes this collision on purpose. It offers a record while rewriting the index, and again while clearing the store bit. It then checks that the buffer write lands at the old index under the old control value, and that the index reads back the software value. A behavioural model steps alongside the design on every clock. It compares the write port, the interrupt and the register read data, so the wrap and the interrupt threshold are judged in the cycle they occur.

// File: rtl/btl_pkg.sv
package btl_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned CTRL_W = 7;
  localparam int unsigned PRIV_W = 2;

  localparam int unsigned C_STORE    = 3;
  localparam int unsigned C_IRQ_MODE = 4;
  localparam int unsigned C_DROP_SUP = 5;
  localparam int unsigned C_DROP_USR = 6;

  typedef enum logic [1:0] {
    RA_CTRL  = 2'd0,
    RA_BASE  = 2'd1,
    RA_INDEX = 2'd2,
    RA_LIMIT = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/btl_regs.sv
module btl_regs
  import btl_pkg::*;
#(
  parameter int unsigned PTR_W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [1:0]           addr_i,
  input  logic [REG_W-1:0]     wdata_i,
  input  logic                 adv_i,
  input  logic [PTR_W-1:0]     idx_next_i,
  output logic [CTRL_W-1:0]    ctrl_o,
  output logic [PTR_W-1:0]     base_o,
  output logic [PTR_W-1:0]     index_o,
  output logic [PTR_W-1:0]     limit_o,
  output logic [REG_W-1:0]     rdata_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [PTR_W-1:0]  base_q, index_q, limit_q;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      base_q  <= '0;
      index_q <= '0;
      limit_q <= '0;
    end else begin
      if (we_i && addr_i == RA_CTRL)  ctrl_q  <= wdata_i[CTRL_W-1:0];
      if (we_i && addr_i == RA_BASE)  base_q  <= wdata_i[PTR_W-1:0];
      if (we_i && addr_i == RA_LIMIT) limit_q <= wdata_i[PTR_W-1:0];
      // software write overrides the advance
      if (we_i && addr_i == RA_INDEX) index_q <= wdata_i[PTR_W-1:0];
      else if (adv_i)                 index_q <= idx_next_i;
    end
  end

  always_comb begin
    unique case (addr_i)
      RA_CTRL:  rdata_o = REG_W'(ctrl_q);
      RA_BASE:  rdata_o = REG_W'(base_q);
      RA_INDEX: rdata_o = REG_W'(index_q);
      default:  rdata_o = REG_W'(limit_q);
    endcase
  end

  assign ctrl_o  = ctrl_q;
  assign base_o  = base_q;
  assign index_o = index_q;
  assign limit_o = limit_q;
endmodule

// File: rtl/btl_ptr.sv
module btl_ptr #(
  parameter int unsigned PTR_W = 16
) (
  input  logic [PTR_W-1:0] base_i,
  input  logic [PTR_W-1:0] index_i,
  input  logic [PTR_W-1:0] limit_i,
  input  logic             circular_i,
  output logic             full_o,
  output logic [PTR_W-1:0] next_o
);
  localparam int unsigned EXT_W = PTR_W + 1;

  logic [EXT_W-1:0] inc;

  assign inc    = EXT_W'(index_i) + EXT_W'(1);
  assign full_o = index_i >= limit_i;

  always_comb begin
    if (circular_i && inc >= EXT_W'(limit_i)) next_o = base_i;
    else                                       next_o = inc[PTR_W-1:0];
  end
endmodule

// File: rtl/btl_filter.sv
module btl_filter
  import btl_pkg::*;
(
  input  logic              valid_i,
  input  logic [PRIV_W-1:0] priv_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              full_i,
  output logic              keep_o
);
  logic is_sup, drop_priv, blocked;

  assign is_sup    = priv_i == '0;
  assign drop_priv = (is_sup && ctrl_i[C_DROP_SUP]) || (!is_sup && ctrl_i[C_DROP_USR]);
  assign blocked   = ctrl_i[C_IRQ_MODE] && full_i;
  assign keep_o    = valid_i && ctrl_i[C_STORE] && !drop_priv && !blocked;
endmodule

// File: rtl/btrace_logger.sv
module btrace_logger
  import btl_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned PTR_W  = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      rec_valid_i,
  output logic                      rec_ready_o,
  input  logic [ADDR_W-1:0]         rec_src_i,
  input  logic [ADDR_W-1:0]         rec_dst_i,
  input  logic [1:0]                rec_priv_i,
  input  logic                      reg_we_i,
  input  logic [1:0]                reg_addr_i,
  input  logic [31:0]               reg_wdata_i,
  output logic [31:0]               reg_rdata_o,
  output logic                      mem_we_o,
  output logic [PTR_W-1:0]          mem_addr_o,
  output logic [2*ADDR_W+1:0]       mem_wdata_o,
  output logic                      irq_o
);
  localparam int unsigned DATA_W = 2 * ADDR_W + PRIV_W;

  logic [CTRL_W-1:0] ctrl_q;
  logic [PTR_W-1:0]  base_q, index_q, limit_q, idx_next;
  logic              full, keep;
  logic              we_q;
  logic [PTR_W-1:0]  addr_q;
  logic [DATA_W-1:0] data_q;

  assign rec_ready_o = 1'b1;

  btl_regs #(.PTR_W(PTR_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .adv_i      (keep),
    .idx_next_i (idx_next),
    .ctrl_o     (ctrl_q),
    .base_o     (base_q),
    .index_o    (index_q),
    .limit_o    (limit_q),
    .rdata_o    (reg_rdata_o)
  );

  btl_ptr #(.PTR_W(PTR_W)) u_ptr (
    .base_i     (base_q),
    .index_i    (index_q),
    .limit_i    (limit_q),
    .circular_i (!ctrl_q[C_IRQ_MODE]),
    .full_o     (full),
    .next_o     (idx_next)
  );

  btl_filter u_filter (
    .valid_i (rec_valid_i),
    .priv_i  (rec_priv_i),
    .ctrl_i  (ctrl_q),
    .full_i  (full),
    .keep_o  (keep)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      we_q <= keep;
      if (keep) begin
        addr_q <= index_q;
        data_q <= {rec_priv_i, rec_dst_i, rec_src_i};
      end
    end
  end

  assign mem_we_o    = we_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = data_q;
  assign irq_o       = ctrl_q[C_STORE] && ctrl_q[C_IRQ_MODE] && full;
endmodule

// File: rtl/btl_checker.sv
module btl_checker #(
  parameter int unsigned PTR_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       rec_priv_i,
  input logic             reg_we_i,
  input logic [1:0]       reg_addr_i,
  input logic [31:0]      reg_rdata_o,
  input logic             mem_we_o,
  input logic [PTR_W-1:0] mem_addr_o,
  input logic             irq_o,
  input logic [6:0]       ctrl_i,
  input logic [PTR_W-1:0] index_i,
  input logic [PTR_W-1:0] limit_i
);
  p_rsvd_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_addr_i == 2'd0 |-> reg_rdata_o[31:7] == '0);

  p_wr_addr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_addr_o == $past(index_i));

  p_store_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(ctrl_i[3]));

  p_drop_sup_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !($past(ctrl_i[5]) && $past(rec_priv_i) == 2'd0));

  p_drop_usr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !($past(ctrl_i[6]) && $past(rec_priv_i) != 2'd0));

  p_full_block_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !$past(irq_o));

  p_irq_level_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> index_i >= limit_i);

  p_irq_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !reg_we_i |=> irq_o);
endmodule

bind btrace_logger btl_checker #(.PTR_W(PTR_W)) u_btl_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rec_priv_i  (rec_priv_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_rdata_o (reg_rdata_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .irq_o       (irq_o),
  .ctrl_i      (ctrl_q),
  .index_i     (index_q),
  .limit_i     (limit_q)
);

// File: tb/btrace_logger_bench.sv
module btrace_logger_bench;
  localparam int AW = 32;
  localparam int PW = 16;
  localparam int DW = 2 * AW + 2;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          rec_valid_i = 1'b0;
  logic          rec_ready_o;
  logic [AW-1:0] rec_src_i = '0, rec_dst_i = '0;
  logic [1:0]    rec_priv_i = '0;
  logic          reg_we_i = 1'b0;
  logic [1:0]    reg_addr_i = '0;
  logic [31:0]   reg_wdata_i = '0;
  logic [31:0]   reg_rdata_o;
  logic          mem_we_o;
  logic [PW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o;
  logic          irq_o;

  always #5ns clk = ~clk;

  btrace_logger #(.ADDR_W(AW), .PTR_W(PW)) u_btrace_logger (
    .clk_i(clk), .rst_ni(rst_ni),
    .rec_valid_i(rec_valid_i), .rec_ready_o(rec_ready_o),
    .rec_src_i(rec_src_i), .rec_dst_i(rec_dst_i), .rec_priv_i(rec_priv_i),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .irq_o(irq_o)
  );

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  // behavioural model state
  int m_ctrl = 0, m_base = 0, m_idx = 0, m_lim = 0;
  bit exp_we = 0;
  int exp_addr = 0;
  logic [DW-1:0] exp_data = '0;

  function automatic int m_read(input int a);
    case (a)
      0: return m_ctrl;
      1: return m_base;
      2: return m_idx;
      default: return m_lim;
    endcase
  endfunction

  function automatic bit m_irq();
    return m_ctrl[3] && m_ctrl[4] && (m_idx >= m_lim);
  endfunction

  task automatic chk(input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  task automatic step(input bit v, input int src, input int dst, input int priv,
                      input bit we, input int addr, input int wdata);
    bit keep, sup, drop;
    int n;
    rec_valid_i = v; rec_src_i = src; rec_dst_i = dst; rec_priv_i = 2'(priv);
    reg_we_i = we; reg_addr_i = 2'(addr); reg_wdata_i = wdata;
    #1ns;
    chk("ready", DW'(rec_ready_o), DW'(1));
    chk("irq", DW'(irq_o), DW'(m_irq()));
    chk("rdata", DW'(reg_rdata_o), DW'(32'(m_read(addr))));
    @(posedge clk);
    sup  = (priv == 0);
    drop = (sup && m_ctrl[5]) || (!sup && m_ctrl[6]);
    keep = v && m_ctrl[3] && !drop && !m_irq();
    exp_we = keep;
    if (keep) begin
      exp_addr = m_idx;
      exp_data = {2'(priv), 32'(dst), 32'(src)};
      n = m_idx + 1;
      if (!m_ctrl[4] && n >= m_lim) n = m_base;
      m_idx = n & 'hFFFF;
    end
    if (we) begin
      case (addr)
        0: m_ctrl = wdata & 'h7F;
        1: m_base = wdata & 'hFFFF;
        2: m_idx  = wdata & 'hFFFF;
        default: m_lim = wdata & 'hFFFF;
      endcase
    end
    @(negedge clk);
    chk("mem_we", DW'(mem_we_o), DW'(exp_we));
    if (exp_we) begin
      chk("mem_addr", DW'(mem_addr_o), DW'(16'(exp_addr)));
      chk("mem_wdata", mem_wdata_o, exp_data);
    end
  endtask

  task automatic wr(input int addr, input int data);
    step(0, 0, 0, 0, 1, addr, data);
  endtask

  task automatic rd(input int addr);
    step(0, 0, 0, 0, 0, addr, 0);
  endtask

  task automatic rec(input int src, input int dst, input int priv);
    step(1, src, dst, priv, 0, 2, 0);
  endtask

  initial begin
    #(200000 * 10ns);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    cur_req = "R1";
    for (int a = 0; a < 4; a++) rd(a);

    cur_req = "R2";
    wr(0, 'hFFFF_FFFF); rd(0);
    wr(1, 'hABCD_1234); rd(1);
    wr(0, 0);
    wr(1, 4); wr(3, 8); wr(2, 4);

    cur_req = "R3";
    wr(0, 'h08);
    rec('h1000, 'h2000, 0);
    rec('h1004, 'h2F00, 1);
    rec('hDEAD_BEEF, 'hCAFE_F00D, 3);
    rd(2);

    cur_req = "R4";
    wr(0, 'h07);
    rec('h11, 'h22, 0); rec('h33, 'h44, 2); rd(2);

    cur_req = "R5";
    wr(0, 'h28); wr(2, 4);
    rec('h50, 'h51, 0); rec('h52, 'h53, 2); rd(2);

    cur_req = "R6";
    wr(0, 'h48);
    rec('h60, 'h61, 1); rec('h62, 'h63, 0); rd(2);

    cur_req = "R7";
    wr(0, 'h68);
    rec('h70, 'h71, 0); rec('h72, 'h73, 3); rd(0); rd(2);

    cur_req = "R8";
    wr(0, 'h08); wr(2, 4);
    for (int i = 0; i < 6; i++) rec('h800 + i, 'h900 + i, i % 4);
    rd(2);

    cur_req = "R9";
    wr(0, 'h18); wr(2, 4);
    for (int i = 0; i < 7; i++) rec('hA00 + i, 'hB00 + i, 1);
    rd(2);

    cur_req = "R10";
    rd(0); rd(1); rd(3);
    wr(2, 5);
    rec('hC00, 'hC01, 2); rd(2);

    cur_req = "R11";
    wr(2, 6);
    step(1, 'hD00, 'hD01, 0, 1, 2, 2);
    rd(2);
    step(1, 'hE00, 'hE01, 1, 1, 0, 'h10);
    rec('hF00, 'hF01, 1); rd(0); rd(2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule